// File: doc/BRIEF.md
# Microstep Phase Indexer for a Two-Phase Bipolar Stepper

This block converts a step pulse stream and a direction level into per-winding current commands for a two-phase bipolar stepper motor. It holds a 64-position electrical phase index, one full electrical cycle at sixteenth-step resolution. On each rising step edge it moves the index by a power-of-two amount picked by a 2-bit resolution code. From the new index it produces, for each winding, a 4-bit current magnitude and a polarity bit. These drive an external chopping bridge and its reference DACs.

Both windings read one quantised quarter-sine profile, and winding B trails winding A by a quarter cycle. At the two zero crossings of a winding, the polarity bit depends on the direction of the last step, so that the driver already points toward the half-cycle the motor is heading into. An idle watchdog built from a prescaler and a wrapping counter removes all drive when steps stop for a long time. The next step brings the drive back.

Top module: `stepper_phase_indexer`

## Requirements
- R1: After reset the phase index is 0 and all four outputs (`mag_a`, `neg_a`, `mag_b`, `neg_b`) are 0 until the first step is accepted.
- R2: Each accepted step moves the index by 1, 2, 4 or 8 positions for `res_sel` codes 0, 1, 2 and 3. The code is sampled in the same cycle as the step edge.
- R3: With `dir_in` high the index grows, and with it low the index shrinks, wrapping modulo 64 both ways. Only a rising edge of `step_in` is a step.
- R4: For an index i, take q = i mod 32. Winding A's magnitude is P[q] for q <= 16 and P[32-q] otherwise, where P[0..16] = 0,1,2,4,5,7,8,9,10,11,12,13,13,14,14,14,15.
- R5: `neg_a` = 1 means negative current. It is 0 for indices 1..31 and 1 for indices 33..63. At index 0 it equals the inverse of the last step's direction, and at index 32 it equals that direction.
- R6: Winding B (`mag_b`, `neg_b`) equals winding A's rule applied to index (i - 16) mod 64. It is therefore at full negative magnitude at index 0, zero at 16 and full positive at 32.
- R7: Both windings' outputs are registered and change on the same clock edge, one clock after the step edge is detected. Counted from the rising input, that is the third clock edge, because of the two-stage input synchroniser. Between steps they hold.
- R8: If PRESCALE_DIV × 2^IDLE_CNT_W × IDLE_WRAPS clocks pass with no step, all four outputs go to 0. Every step restarts this interval.
- R9: After an idle timeout, the next step updates the index as usual and restores drive outputs computed from the new index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_in | input | 1 | Step pulse, asynchronous, rising edge active |
| dir_in | input | 1 | Direction level, asynchronous, 1 = increasing index |
| res_sel | input | 2 | Resolution code, 0..3 = 1/16, 1/8, 1/4, 1/2 step |
| mag_a | output | 4 | Winding A current magnitude |
| neg_a | output | 1 | Winding A polarity, 1 = negative |
| mag_b | output | 4 | Winding B current magnitude |
| neg_b | output | 1 | Winding B polarity, 1 = negative |

## Verification
The assertions take for granted that `dir_in` and `res_sel` are steady for at least the two synchroniser clocks around each rising step edge, and that step pulses stay high and low for several clocks each. When those hold, the sampled direction and resolution belong to the step being taken. The bench sets direction and resolution at the same moment it raises the step, holds the step high for three clocks and low for three more, and changes nothing while a step is in flight. Idle timeout tests use a small prescaler and counter so the full idle interval fits in a few hundred clocks.

// File: rtl/stepper_pkg.sv
// Package: shared constants and the quantised quarter-sine current profile.
// Assumes a 64-position electrical cycle and 4-bit magnitudes.
package stepper_pkg;
    localparam int PHASE_W   = 6;                 // 64 positions per electrical cycle
    localparam int MAG_W     = 4;                 // current magnitude width
    localparam int HALF_POS  = 1 << (PHASE_W - 1); // 32
    localparam int QUART_POS = 1 << (PHASE_W - 2); // 16

    // Quarter-wave magnitude for q in 0..16
    function automatic logic [MAG_W-1:0] quarter_mag(input logic [PHASE_W-2:0] q);
        case (q)
            5'd0:  quarter_mag = 4'd0;
            5'd1:  quarter_mag = 4'd1;
            5'd2:  quarter_mag = 4'd2;
            5'd3:  quarter_mag = 4'd4;
            5'd4:  quarter_mag = 4'd5;
            5'd5:  quarter_mag = 4'd7;
            5'd6:  quarter_mag = 4'd8;
            5'd7:  quarter_mag = 4'd9;
            5'd8:  quarter_mag = 4'd10;
            5'd9:  quarter_mag = 4'd11;
            5'd10: quarter_mag = 4'd12;
            5'd11: quarter_mag = 4'd13;
            5'd12: quarter_mag = 4'd13;
            5'd13: quarter_mag = 4'd14;
            5'd14: quarter_mag = 4'd14;
            5'd15: quarter_mag = 4'd14;
            default: quarter_mag = 4'd15;
        endcase
    endfunction

    // Magnitude for a full-cycle index: fold the half cycle onto the quarter
    function automatic logic [MAG_W-1:0] phase_mag(input logic [PHASE_W-1:0] idx);
        logic [PHASE_W-2:0] q;
        q = idx[PHASE_W-2:0];
        if (q > (PHASE_W-1)'(QUART_POS))
            q = (PHASE_W-1)'(HALF_POS) - q;
        return quarter_mag(q);
    endfunction

    // Polarity: upper half negative; at a zero crossing point toward the travel
    function automatic logic phase_neg(input logic [PHASE_W-1:0] idx, input logic up);
        if (idx[PHASE_W-2:0] == '0)
            return idx[PHASE_W-1] ? up : ~up;
        return idx[PHASE_W-1];
    endfunction
endpackage

// File: rtl/step_sync.sv
// Module: two-flop synchroniser for step and direction plus step rising-edge
// detector. Assumes direction settles no later than the step rises.
module step_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic dir_in,
    output logic step_rise,
    output logic dir_sync
);
    logic [STAGES-1:0] step_sh;
    logic [STAGES-1:0] dir_sh;
    logic              step_last;

    // Shift the asynchronous inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_sh   <= '0;
            dir_sh    <= '0;
            step_last <= 1'b0;
        end else begin
            step_sh   <= {step_sh[STAGES-2:0], step_in};
            dir_sh    <= {dir_sh[STAGES-2:0], dir_in};
            step_last <= step_sh[STAGES-1];
        end
    end

    assign step_rise = step_sh[STAGES-1] & ~step_last;
    assign dir_sync  = dir_sh[STAGES-1];
endmodule

// File: rtl/phase_accum.sv
// Module: electrical phase index register. Moves by 2^res on each step,
// up or down, wrapping at the index width.
module phase_accum
    import stepper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_rise,
    input  logic               up,
    input  logic [1:0]         res,
    output logic [PHASE_W-1:0] idx_q,
    output logic [PHASE_W-1:0] idx_next
);
    logic [PHASE_W-1:0] inc;

    // Step size and the candidate next index
    always_comb begin
        inc      = PHASE_W'(1) << res;
        idx_next = up ? idx_q + inc : idx_q - inc;
    end

    // Commit the new index on an accepted step
    always_ff @(posedge clk) begin
        if (!rst_n)         idx_q <= '0;
        else if (step_rise) idx_q <= idx_next;
    end
endmodule

// File: rtl/idle_watch.sv
// Module: idle watchdog. A prescaler ticks a CNT_W-bit counter; after WRAPS
// wraps with no clear, emits a single expire pulse and stops until cleared.
module idle_watch #(
    parameter int PRESCALE = 256,
    parameter int CNT_W    = 16,
    parameter int WRAPS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expire
);
    localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int WRAP_W = $clog2(WRAPS + 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  idle_cnt;
    logic [WRAP_W-1:0] wrap_cnt;
    logic              done;
    logic              tick;
    logic              cnt_top;

    assign tick    = (pre_cnt == PRE_W'(PRESCALE - 1));
    assign cnt_top = (idle_cnt == '1);
    assign expire  = !done && tick && cnt_top && (wrap_cnt == WRAP_W'(WRAPS - 1));

    // Prescaler: free-running, restarted by a step
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pre_cnt <= '0;
        else if (tick)       pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + 1'b1;
    end

    // Idle counter and wrap tally; frozen once the timeout has fired
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idle_cnt <= '0;
            wrap_cnt <= '0;
            done     <= 1'b0;
        end else if (!done && tick) begin
            idle_cnt <= idle_cnt + 1'b1;
            if (cnt_top) begin
                if (wrap_cnt == WRAP_W'(WRAPS - 1)) done <= 1'b1;
                else                                wrap_cnt <= wrap_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/winding_map.sv
// Module: combinational map from phase index to one winding's magnitude and
// polarity. OFFSET positions of lag select the winding.
module winding_map
    import stepper_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic [PHASE_W-1:0] idx,
    input  logic               up,
    output logic [MAG_W-1:0]   mag,
    output logic               neg
);
    logic [PHASE_W-1:0] local_idx;

    // Shift by the winding's lag, then look up the profile
    always_comb begin
        local_idx = idx - PHASE_W'(OFFSET);
        mag       = phase_mag(local_idx);
        neg       = phase_neg(local_idx, up);
    end
endmodule

// File: rtl/stepper_phase_indexer.sv
// Module: step/direction microstep indexer, top level. Synchronises inputs,
// moves the phase index, maps it to two windings in quadrature and registers
// the drive. Idle timeout zeroes the drive until the next step.
module stepper_phase_indexer
    import stepper_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PRESCALE_DIV = 256,
    parameter int IDLE_CNT_W   = 16,
    parameter int IDLE_WRAPS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [1:0]       res_sel,
    output logic [MAG_W-1:0] mag_a,
    output logic             neg_a,
    output logic [MAG_W-1:0] mag_b,
    output logic             neg_b
);
    localparam int NUM_WIND = 2;

    logic               step_edge;
    logic               dir_s;
    logic               idle_expire;
    logic [PHASE_W-1:0] idx_q;
    logic [PHASE_W-1:0] idx_next;
    logic [MAG_W-1:0]   wmag [NUM_WIND];
    logic               wneg [NUM_WIND];

    step_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .step_rise(step_edge), .dir_sync(dir_s)
    );

    phase_accum u_accum (
        .clk(clk), .rst_n(rst_n), .step_rise(step_edge), .up(dir_s),
        .res(res_sel), .idx_q(idx_q), .idx_next(idx_next)
    );

    idle_watch #(
        .PRESCALE(PRESCALE_DIV), .CNT_W(IDLE_CNT_W), .WRAPS(IDLE_WRAPS)
    ) u_idle (
        .clk(clk), .rst_n(rst_n), .clear(step_edge), .expire(idle_expire)
    );

    // One map per winding, each lagging by a quarter cycle more
    for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
        winding_map #(.OFFSET(w * QUART_POS)) u_map (
            .idx(idx_next), .up(dir_s), .mag(wmag[w]), .neg(wneg[w])
        );
    end

    // Register both windings together; step wins over idle timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a <= '0; neg_a <= 1'b0;
            mag_b <= '0; neg_b <= 1'b0;
        end else if (step_edge) begin
            mag_a <= wmag[0]; neg_a <= wneg[0];
            mag_b <= wmag[1]; neg_b <= wneg[1];
        end else if (idle_expire) begin
            mag_a <= '0; neg_a <= 1'b0;
            mag_b <= '0; neg_b <= 1'b0;
        end
    end
endmodule

// File: rtl/stepper_indexer_chk.sv
// Checker: properties of the indexer, bound into the top module.
module stepper_indexer_chk
    import stepper_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               step_edge,
    input logic               step_dir,
    input logic [1:0]         res,
    input logic [PHASE_W-1:0] idx,
    input logic               expire,
    input logic [MAG_W-1:0]   mag_a,
    input logic               neg_a,
    input logic [MAG_W-1:0]   mag_b,
    input logic               neg_b
);
    logic       seen_step;
    logic       any_drive;
    logic [PHASE_W-1:0] inc;

    assign any_drive = (mag_a != '0) || neg_a || (mag_b != '0) || neg_b;
    assign inc       = PHASE_W'(1) << res;

    // Track whether any step has been accepted since reset
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_step <= 1'b0;
        else if (step_edge) seen_step <= 1'b1;
    end

    assert_quiet_before_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_step |-> !any_drive);

    assert_index_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && step_dir) |=> idx == $past(idx) + $past(inc));

    assert_index_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && !step_dir) |=> idx == $past(idx) - $past(inc));

    assert_pol_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_a != '0) |-> neg_a == idx[PHASE_W-1]);

    assert_quadrature_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_drive |-> ({1'b0, mag_a} + {1'b0, mag_b}) >= 5'd15);

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_edge && !expire) |=> $stable({mag_a, neg_a, mag_b, neg_b}));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !step_edge) |=> !any_drive);
endmodule

bind stepper_phase_indexer stepper_indexer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .step_edge(step_edge), .step_dir(dir_s),
    .res(res_sel), .idx(idx_q), .expire(idle_expire),
    .mag_a(mag_a), .neg_a(neg_a), .mag_b(mag_b), .neg_b(neg_b)
);

// File: tb/tb_stepper_phase_indexer.sv
// Bench: scoreboard. The driver pushes expected drive words; the monitor pops
// and compares when the driver signals that results are due.
module tb_stepper_phase_indexer;
    localparam int PRE = 4, CW = 4, WR = 4;
    localparam int IDLE_CLKS = PRE * (1 << CW) * WR; // 256

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 1'b0, dir_in = 1'b0;
    logic [1:0] res_sel = 2'd0;
    logic [3:0] mag_a, mag_b;
    logic neg_a, neg_b;

    int checks = 0, fails = 0;
    int m_idx = 0;
    logic [9:0] last_exp = '0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #2 clk = ~clk; // 250 MHz

    stepper_phase_indexer #(.PRESCALE_DIV(PRE), .IDLE_CNT_W(CW), .IDLE_WRAPS(WR)) dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in), .res_sel(res_sel),
        .mag_a(mag_a), .neg_a(neg_a), .mag_b(mag_b), .neg_b(neg_b)
    );

    // Independent model of one winding: {neg, mag}
    function automatic logic [4:0] model_wind(int i, bit up);
        int prof[17] = '{0,1,2,4,5,7,8,9,10,11,12,13,13,14,14,14,15};
        int a, m; bit n;
        i = ((i % 64) + 64) % 64;
        a = i % 32;
        m = (a <= 16) ? prof[a] : prof[32 - a];
        if (a == 0) n = (i == 0) ? !up : up;
        else        n = (i > 32);
        return {n, 4'(m)};
    endfunction

    function automatic logic [9:0] model_out(int i, bit up);
        logic [4:0] wa, wb;
        wa = model_wind(i, up);
        wb = model_wind(i + 48, up);
        return {wa[3:0], wa[4], wb[3:0], wb[4]};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {mag_a, neg_a, mag_b, neg_b};
    endfunction

    // Driver: one step pulse; pushes the expected word, checks latency (R7)
    task automatic do_step(bit up, logic [1:0] r, string tag);
        @(negedge clk);
        dir_in = up; res_sel = r; step_in = 1'b1;
        m_idx = (((m_idx + (up ? (1 << r) : -(1 << r))) % 64) + 64) % 64;
        exp_q.push_back(model_out(m_idx, up));
        tag_q.push_back(tag);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 outputs unchanged before third edge", outs(), last_exp);
        @(posedge clk);
        @(negedge clk);
        ->chk_ev;
        #0;
        step_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare design output against the next expected word
    initial begin
        forever begin
            @(chk_ev);
            last_exp = exp_q.pop_front();
            check(tag_q.pop_front(), outs(), last_exp);
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset outputs zero", outs(), 10'd0);

        // Full cycle forward at 1/16: covers profile, polarity, crossings, wrap
        for (int k = 0; k < 64; k++) do_step(1'b1, 2'd0, "R2 R3 R4 R5 R6 forward 1/16");
        // Back through index 0 and forward again to hit the crossing both ways
        do_step(1'b0, 2'd0, "R3 wrap below zero");
        do_step(1'b1, 2'd0, "R5 crossing at 0 moving up");
        do_step(1'b0, 2'd0, "R5 R3 back to 63");
        do_step(1'b1, 2'd0, "R5 up to 0");
        for (int k = 0; k < 10; k++) do_step(1'b0, 2'd3, "R2 R3 half step down");
        for (int k = 0; k < 10; k++) do_step(1'b1, 2'd1, "R2 eighth step up");
        for (int k = 0; k < 10; k++) do_step(1'b0, 2'd2, "R2 quarter step down");
        for (int k = 0; k < 20; k++) do_step(1'b0, 2'd0, "R4 R6 sixteenth down");

        // Falling edge alone is not a step (R3): stay high long, drop, wait
        @(negedge clk) step_in = 1'b1; dir_in = 1'b1; res_sel = 2'd0;
        m_idx = (m_idx + 1) % 64;
        repeat (6) @(negedge clk);
        last_exp = model_out(m_idx, 1'b1);
        check("R3 rising edge step taken", outs(), last_exp);
        step_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 falling edge ignored", outs(), last_exp);

        // Steps restart the idle interval (R8)
        do_step(1'b1, 2'd0, "R8 step before idle wait");
        repeat (IDLE_CLKS - 60) @(negedge clk);
        do_step(1'b1, 2'd0, "R8 step restarts timer");
        repeat (IDLE_CLKS - 60) @(negedge clk);
        check("R8 still driving after restarted interval", outs(), last_exp);

        // Let the idle timeout fire
        repeat (80) @(negedge clk);
        check("R8 drive removed after idle", outs(), 10'd0);
        last_exp = '0;
        do_step(1'b0, 2'd2, "R9 restore after timeout");
        do_step(1'b1, 2'd3, "R9 second step after restore");

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule